// File: doc/BRIEF.md
# FIR Filter Start and Reset Sequencer

This block decides when a FIR filter engine begins to process samples, and it restores the engine's configuration word after a qualified reset. Which start rule applies depends on two inputs. In one case the engine starts by itself as soon as the coefficient transfer is done. In the other it waits for an external enable strobe, so that processing can line up with a data stream that is already running. The enable strobe arrives together with the first valid sample, and both are taken in on the next rising clock edge.

The reset input is filtered. A low level counts only after it has been held for a minimum number of consecutive clock edges. Shorter dips are ignored. A qualified reset stops the engine and reloads the fixed default configuration word. While the engine runs, a periodic strobe marks each sample period. One pulse tells the engine both that a new input sample is needed and that a new result is ready. The sample period is a parameter and is one clock by default.

Top module: `fir_start_ctrl`

## Requirements
- R1: When `rstN` is sampled low on RST_MIN (default 16) consecutive rising edges, the block takes reset at the last of those edges. `runFlag`, `captureStrb` and `sampleTick` are then low. It stays in reset on every further low edge. The low-edge count returns to zero on any edge where `rstN` is high.
- R2: A low period on `rstN` of RST_MIN-1 edges or fewer has no effect. `runFlag`, `sampleTick` and `ctrlWord` continue exactly as if `rstN` had stayed high.
- R3: After a qualified reset, `ctrlWord` reads 16'h8C80 and holds that value. This word selects single filter, sample rate equal to clock rate, no decimation, not cascaded, and bank selection taken from the register bit.
- R4: With `loadFromRom` = 1 and `freeRun` = 1, `runFlag` rises at the first rising edge that samples `coefLoaded` high. `startStrobe` is not needed. Until that edge `runFlag` stays low.
- R5: With `freeRun` = 0, in either load mode, `runFlag` rises only at a rising edge that samples both `startStrobe` and `coefLoaded` high. An edge where `startStrobe` is high and `coefLoaded` is low does not start the engine.
- R6: With `loadFromRom` = 0 (host load mode), `freeRun` = 1 does not give an automatic start. The engine waits for `startStrobe` as in R5.
- R7: `captureStrb` is high for exactly one cycle: the first cycle in which `runFlag` is high. This is the cycle after the edge that took in the enable strobe and the first sample.
- R8: Once set, `runFlag` stays high until the next qualified reset. While it is high, further `startStrobe` pulses give no new `captureStrb`.
- R9: While running, `sampleTick` is high in the first running cycle and then once every RATE_DIV cycles. With the default RATE_DIV = 1 it is high on every running cycle.
- R10: `sampleTick` is low whenever `runFlag` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rstN | input | 1 | Active-low reset request, honoured only after the minimum hold |
| freeRun | input | 1 | 1 selects automatic start in ROM load mode; 0 waits for the enable strobe |
| startStrobe | input | 1 | Filter enable, raised together with the first valid sample |
| coefLoaded | input | 1 | High once the coefficient transfer has finished |
| loadFromRom | input | 1 | Load mode: 1 = stand-alone ROM load, 0 = host load |
| runFlag | output | 1 | High while the filter engine is processing |
| captureStrb | output | 1 | One-cycle strobe marking the first sample capture |
| sampleTick | output | 1 | Per-sample-period strobe: input wanted and result ready |
| ctrlWord | output | 16 | Current configuration word |

## Verification
A reset low-counter that is off by one either honours a pulse of RST_MIN-1 edges or misses one of RST_MIN edges. Either fault shows at `runFlag` on the very edge where the count expires, so the bench uses pulses at both lengths. A wrong start decode shows as `runFlag` and `captureStrb` rising one or more cycles early or late, or not rising at all. A stale phase counter shows as `sampleTick` shifted within the period on the second instance, which runs with a divisor of three. The behavioural model is compared on every clock, so each of these faults is reported in the cycle where it first appears.

// File: rtl/fir_start_pkg.sv
package fir_start_pkg;
  // strobes passed from the control half to the datapath half
  typedef struct packed {
    logic cfgReset;  // qualified reset taken this edge
    logic startNow;  // run begins at this edge
    logic running;   // engine currently processing
  } startStrb_t;
endpackage

// File: rtl/fir_start_ctl.sv
module fir_start_ctl
  import fir_start_pkg::*;
#(
  parameter int RST_MIN = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       freeRun,
  input  logic       startStrobe,
  input  logic       coefLoaded,
  input  logic       loadFromRom,
  output logic       runFlag,
  output logic       captureStrb,
  output startStrb_t strb
);
  localparam int CW = (RST_MIN > 2) ? $clog2(RST_MIN) : 1;
  localparam logic [CW-1:0] LAST = CW'(RST_MIN - 1);

  logic [CW-1:0] lowCnt;
  logic          resetHit;
  logic          autoStart;
  logic          startNow;
  logic          runReg;
  logic          capReg;

  // saturating count of consecutive low edges
  always_ff @(posedge clk) begin
    if (rstN)              lowCnt <= '0;
    else if (lowCnt != LAST) lowCnt <= lowCnt + 1'b1;
  end

  assign resetHit  = !rstN && (lowCnt == LAST);
  assign autoStart = freeRun && loadFromRom;
  assign startNow  = !runReg && !resetHit && coefLoaded && (autoStart || startStrobe);

  always_ff @(posedge clk) begin
    if (resetHit) begin
      runReg <= 1'b0;
      capReg <= 1'b0;
    end else begin
      if (startNow) runReg <= 1'b1;
      capReg <= startNow;
    end
  end

  assign runFlag       = runReg;
  assign captureStrb   = capReg;
  assign strb.cfgReset = resetHit;
  assign strb.startNow = startNow;
  assign strb.running  = runReg;
endmodule

// File: rtl/fir_start_dp.sv
module fir_start_dp
  import fir_start_pkg::*;
#(
  parameter int          RATE_DIV     = 1,
  parameter logic [15:0] DEFAULT_WORD = 16'h8C80
) (
  input  logic        clk,
  input  startStrb_t  strb,
  output logic        sampleTick,
  output logic [15:0] ctrlWord
);
  logic [15:0] wordReg;
  logic        phaseZero;

  always_ff @(posedge clk) begin
    if (strb.cfgReset) wordReg <= DEFAULT_WORD;
  end

  generate
    if (RATE_DIV <= 1) begin : g_full_rate
      assign phaseZero = 1'b1;
    end else begin : g_divided
      localparam int PW = $clog2(RATE_DIV);
      localparam logic [PW-1:0] PLAST = PW'(RATE_DIV - 1);
      logic [PW-1:0] phase;
      always_ff @(posedge clk) begin
        if (strb.cfgReset || strb.startNow) phase <= '0;
        else if (strb.running)              phase <= (phase == PLAST) ? '0 : phase + 1'b1;
      end
      assign phaseZero = (phase == '0);
    end
  endgenerate

  assign sampleTick = strb.running && phaseZero;
  assign ctrlWord   = wordReg;
endmodule

// File: rtl/fir_start_ctrl.sv
module fir_start_ctrl
  import fir_start_pkg::*;
#(
  parameter int          RST_MIN      = 16,
  parameter int          RATE_DIV     = 1,
  parameter logic [15:0] DEFAULT_WORD = 16'h8C80
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        freeRun,
  input  logic        startStrobe,
  input  logic        coefLoaded,
  input  logic        loadFromRom,
  output logic        runFlag,
  output logic        captureStrb,
  output logic        sampleTick,
  output logic [15:0] ctrlWord
);
  startStrb_t strb;
  logic       cfgResetTap;

  fir_start_ctl #(.RST_MIN(RST_MIN)) u_ctl (
    .clk(clk), .rstN(rstN), .freeRun(freeRun), .startStrobe(startStrobe),
    .coefLoaded(coefLoaded), .loadFromRom(loadFromRom),
    .runFlag(runFlag), .captureStrb(captureStrb), .strb(strb)
  );

  fir_start_dp #(.RATE_DIV(RATE_DIV), .DEFAULT_WORD(DEFAULT_WORD)) u_dp (
    .clk(clk), .strb(strb), .sampleTick(sampleTick), .ctrlWord(ctrlWord)
  );

  assign cfgResetTap = strb.cfgReset;
endmodule

// File: rtl/fir_start_chk.sv
module fir_start_chk #(
  parameter logic [15:0] DEFAULT_WORD = 16'h8C80
) (
  input logic        clk,
  input logic        freeRun,
  input logic        startStrobe,
  input logic        loadFromRom,
  input logic        runFlag,
  input logic        captureStrb,
  input logic        sampleTick,
  input logic [15:0] ctrlWord,
  input logic        inReset
);
  bit armed = 1'b0;
  always_ff @(posedge clk) armed <= armed | (inReset === 1'b1);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!armed)
    inReset |=> (!runFlag && !captureStrb && !sampleTick && ctrlWord == DEFAULT_WORD));
  // R5
  fen_gate_chk: assert property (@(posedge clk) disable iff (!armed)
    (!runFlag && !startStrobe && !(freeRun && loadFromRom)) |=> !runFlag);
  // R7
  capture_once_chk: assert property (@(posedge clk) disable iff (!armed)
    captureStrb |=> !captureStrb);
  // R7
  capture_rise_chk: assert property (@(posedge clk) disable iff (!armed)
    $rose(runFlag) |-> captureStrb);
  // R8
  run_hold_chk: assert property (@(posedge clk) disable iff (!armed)
    (runFlag && !inReset) |=> runFlag);
  // R9
  first_tick_chk: assert property (@(posedge clk) disable iff (!armed)
    captureStrb |-> sampleTick);
  // R10
  tick_idle_chk: assert property (@(posedge clk) disable iff (!armed)
    !runFlag |-> !sampleTick);
endmodule

bind fir_start_ctrl fir_start_chk #(.DEFAULT_WORD(DEFAULT_WORD)) u_chk (
  .clk(clk), .freeRun(freeRun), .startStrobe(startStrobe), .loadFromRom(loadFromRom),
  .runFlag(runFlag), .captureStrb(captureStrb), .sampleTick(sampleTick),
  .ctrlWord(ctrlWord), .inReset(cfgResetTap)
);

// File: tb/tb_fir_start_ctrl.sv
module tb_fir_start_ctrl;
  localparam int CLK_P = 10;
  localparam int WATCHDOG = 5000;

  logic clk = 1'b0;
  logic rstN = 1'b1, freeRun = 1'b0, startStrobe = 1'b0, coefLoaded = 1'b0, loadFromRom = 1'b0;
  logic runFlag, captureStrb, sampleTick, runFlag3, capture3, tick3;
  logic [15:0] ctrlWord, ctrlWord3;

  int checks = 0, fails = 0, cycles = 0;

  // reference model state
  int  lows = 0;
  bit  valid = 0, mRun = 0, mCap = 0;
  int  mPh3 = 0;

  always #(CLK_P/2) clk = ~clk;

  fir_start_ctrl dut (
    .clk(clk), .rstN(rstN), .freeRun(freeRun), .startStrobe(startStrobe),
    .coefLoaded(coefLoaded), .loadFromRom(loadFromRom), .runFlag(runFlag),
    .captureStrb(captureStrb), .sampleTick(sampleTick), .ctrlWord(ctrlWord)
  );

  fir_start_ctrl #(.RATE_DIV(3)) dutDiv (
    .clk(clk), .rstN(rstN), .freeRun(freeRun), .startStrobe(startStrobe),
    .coefLoaded(coefLoaded), .loadFromRom(loadFromRom), .runFlag(runFlag3),
    .captureStrb(capture3), .sampleTick(tick3), .ctrlWord(ctrlWord3)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // model update at each edge, comparison shortly after
  always @(posedge clk) begin
    bit hit, st;
    cycles++;
    hit = !rstN && lows >= 15;
    lows = rstN ? 0 : lows + 1;
    if (hit) begin
      valid = 1; mRun = 0; mCap = 0; mPh3 = 0;
    end else begin
      st = !mRun && coefLoaded && ((freeRun && loadFromRom) || startStrobe);
      mCap = st;
      if (st) begin mRun = 1; mPh3 = 0; end
      else if (mRun) mPh3 = (mPh3 + 1) % 3;
    end
    #(CLK_P/4);
    if (valid) begin
      check("R5 runFlag", {15'd0, runFlag}, {15'd0, mRun});
      check("R7 captureStrb", {15'd0, captureStrb}, {15'd0, mCap});
      check("R9 sampleTick", {15'd0, sampleTick}, {15'd0, mRun});
      check("R9 sampleTick div3", {15'd0, tick3}, {15'd0, mRun && mPh3 == 0});
      check("R8 runFlag div3", {15'd0, runFlag3}, {15'd0, mRun});
      check("R3 ctrlWord", ctrlWord, 16'h8C80);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic lowPulse(input int n);
    @(negedge clk) rstN = 1'b0;
    idle(n);
    rstN = 1'b1;
  endtask

  initial begin
    idle(2);
    lowPulse(20);
    idle(1);
    // R1 reset state
    check("R1 reset run", {15'd0, runFlag}, 16'd0);
    check("R10 idle tick", {15'd0, sampleTick}, 16'd0);
    check("R3 default word", ctrlWord, 16'h8C80);

    // R4 automatic start in ROM mode
    loadFromRom = 1'b1; freeRun = 1'b1;
    idle(5);
    check("R4 waits for coef", {15'd0, runFlag}, 16'd0);
    coefLoaded = 1'b1;
    @(negedge clk);
    check("R4 auto start", {15'd0, runFlag}, 16'd1);
    check("R7 capture", {15'd0, captureStrb}, 16'd1);
    idle(4);
    startStrobe = 1'b1; @(negedge clk); startStrobe = 1'b0; @(negedge clk);
    check("R8 no recapture", {15'd0, captureStrb}, 16'd0);

    // R2 short reset ignored
    lowPulse(15);
    idle(2);
    check("R2 short pulse", {15'd0, runFlag}, 16'd1);

    // R1 exact minimum honoured
    lowPulse(16);
    check("R1 exact min", {15'd0, runFlag}, 16'd0);
    freeRun = 1'b0;
    idle(5);
    check("R5 waits fen", {15'd0, runFlag}, 16'd0);
    check("R10 no tick", {15'd0, tick3}, 16'd0);
    startStrobe = 1'b1; @(negedge clk); startStrobe = 1'b0;
    check("R5 fen start", {15'd0, runFlag}, 16'd1);
    idle(10);

    // R6 host mode ignores freeRun
    lowPulse(18);
    loadFromRom = 1'b0; freeRun = 1'b1; coefLoaded = 1'b0;
    idle(4);
    check("R6 no auto start", {15'd0, runFlag}, 16'd0);
    startStrobe = 1'b1; @(negedge clk); startStrobe = 1'b0;
    check("R5 coef gate", {15'd0, runFlag}, 16'd0);
    coefLoaded = 1'b1;
    idle(3);
    check("R6 still idle", {15'd0, runFlag}, 16'd0);
    startStrobe = 1'b1; @(negedge clk); startStrobe = 1'b0;
    check("R6 fen start", {15'd0, runFlag}, 16'd1);
    idle(12);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_P * WATCHDOG);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule